// File: doc/BRIEF.md
# Clocked Serial Memory Streamer

This block reads a 128-byte storage array in a continuous loop and shifts it out, one bit per rising edge of a slow external stream clock, onto an open-drain data line. The stream clock is asynchronous to the system clock. It passes through a two-flop synchroniser, and each rising edge becomes a single-cycle pulse that advances the sequencer.

The sequencer has four enumerated states:
- **ST_SYNC** keeps the line released while it counts the power-up synchronisation window.
- **ST_PRIME** keeps the line released with the byte pointer at 00h, ready to send that byte's top bit.
- **ST_DATA** drives the eight data bits of the current byte, most significant first.
- **ST_NULL** releases the line for the ninth slot of each byte frame. The pointer has already moved on, so the next byte is fetched during this slot.

The transitions are:
- SYNC to PRIME on the ninth edge.
- PRIME to DATA on the next edge.
- DATA to NULL on the edge after the eighth bit.
- NULL to DATA on the next edge.
- Any state to PRIME on a restart request. A restart takes priority over an edge in the same cycle.

The mode controller owns the enable. While the enable is low, the line is released and stream-clock edges are ignored.

Top module: `stm_streamer`

## Requirements
- R1: After reset the line is released (`line_oe`=0) and `rd_addr` is 00h.
- R2: The first nine stream-clock rising edges after reset leave the line released. The tenth drives the most significant bit of the byte at 00h.
- R3: In the data state, each rising edge of the stream clock drives the next bit of the current byte, bit 7 first and bit 0 last. During a data bit `line_oe`=1 and `line_dat` carries the bit. Falling edges of the stream clock change nothing.
- R4: The ninth slot of every byte frame is a null bit, during which `line_oe`=0.
- R5: Bytes go out in ascending address order. After 7Fh the pointer wraps to 00h and streaming continues.
- R6: A one-cycle `restart_req` releases the line and sets `rd_addr` to 00h on the next clock. The next rising edge then drives bit 7 of byte 00h, with no new synchronisation window, even when the request arrives inside the window.
- R7: While `run_en` is 0 the line is released and rising edges leave the bit position and `rd_addr` unchanged. When `run_en` returns, the bit that was pending is driven again and streaming resumes from there.
- R8: The array has one clock of read latency. `rd_addr` moves to the next byte's address when the null slot begins, so that byte is fetched before its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strm_clk | input | 1 | Asynchronous slow stream clock |
| run_en | input | 1 | Enable from the mode controller |
| restart_req | input | 1 | One-cycle request to restart from byte 00h |
| rd_addr | output | 7 | Array read address |
| rd_data | input | 8 | Array read data, valid one clock after `rd_addr` |
| line_oe | output | 1 | Data line output enable |
| line_dat | output | 1 | Data line value (1 when not driving) |

## Verification
On every cycle, the assertions check that the line is released in the sync state, in the null state and while disabled. They also check that the pointer only steps by one or returns to zero, that it holds while the block is disabled, and that a restart lands in the priming state at address 00h. The bench scenarios are what show the actual bit order, the values read from the array, the exact edge on which the sync window ends, the wrap after 7Fh, and resumption of the pending bit after a pause.

// File: rtl/stm_pkg.sv
`timescale 1ns/1ps
package stm_pkg;
    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_PRIME = 2'd1,
        ST_DATA  = 2'd2,
        ST_NULL  = 2'd3
    } stm_state_e;
endpackage

// File: rtl/stm_edge_sync.sv
`timescale 1ns/1ps
module stm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_p
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_p = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/stm_seq_ctrl.sv
`timescale 1ns/1ps
module stm_seq_ctrl
    import stm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int BITS       = 8,
    parameter int SYNC_EDGES = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_p,
    input  logic              run_en,
    input  logic              restart,
    output stm_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              load_o,
    output logic              shift_o
);
    localparam int CNT_W = $clog2(SYNC_EDGES);
    localparam int BIT_W = $clog2(BITS);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_EDGES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BITS - 1);

    stm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  sync_cnt_q;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              adv;

    assign adv = edge_p & run_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC:  if (adv && sync_cnt_q == SYNC_LAST) state_d = ST_PRIME;
            ST_PRIME: if (adv) state_d = ST_DATA;
            ST_DATA:  if (adv && bit_cnt_q == BIT_LAST) state_d = ST_NULL;
            ST_NULL:  if (adv) state_d = ST_DATA;
        endcase
        if (restart) state_d = ST_PRIME;
    end

    // counters and byte pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_cnt_q <= '0;
            bit_cnt_q  <= '0;
            addr_q     <= '0;
        end else if (restart) begin
            bit_cnt_q <= '0;
            addr_q    <= '0;
        end else if (adv) begin
            unique case (state_q)
                ST_SYNC: sync_cnt_q <= sync_cnt_q + 1'b1;
                ST_DATA: begin
                    if (bit_cnt_q == BIT_LAST) begin
                        bit_cnt_q <= '0;
                        addr_q    <= addr_q + 1'b1;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end
                end
                ST_PRIME, ST_NULL: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        addr_o  = addr_q;
        load_o  = adv && !restart && (state_q == ST_PRIME || state_q == ST_NULL);
        shift_o = adv && !restart && (state_q == ST_DATA) && (bit_cnt_q != BIT_LAST);
    end
endmodule

// File: rtl/stm_shifter.sv
`timescale 1ns/1ps
module stm_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic [BITS-1:0] din,
    output logic            msb
);
    logic [BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '1;
        else if (load)  sh_q <= din;
        else if (shift) sh_q <= {sh_q[BITS-2:0], 1'b1};
    end

    assign msb = sh_q[BITS-1];
endmodule

// File: rtl/stm_streamer.sv
`timescale 1ns/1ps
module stm_streamer
    import stm_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int BITS       = 8,
    parameter int SYNC_EDGES = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strm_clk,
    input  logic              run_en,
    input  logic              restart_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BITS-1:0]   rd_data,
    output logic              line_oe,
    output logic              line_dat
);
    logic       rise_p;
    logic       load, shift, msb;
    stm_state_e st_q;

    stm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(strm_clk), .rise_p(rise_p)
    );

    stm_seq_ctrl #(.ADDR_W(ADDR_W), .BITS(BITS), .SYNC_EDGES(SYNC_EDGES)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .edge_p(rise_p), .run_en(run_en),
        .restart(restart_req), .state_o(st_q), .addr_o(rd_addr),
        .load_o(load), .shift_o(shift)
    );

    stm_shifter #(.BITS(BITS)) shift_i (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(rd_data), .msb(msb)
    );

    // line outputs
    always_comb begin
        line_oe  = run_en && (st_q == ST_DATA);
        line_dat = line_oe ? msb : 1'b1;
    end
endmodule

// File: rtl/stm_streamer_chk.sv
`timescale 1ns/1ps
module stm_streamer_chk
    import stm_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              restart_req,
    input logic              line_oe,
    input logic [ADDR_W-1:0] rd_addr,
    input stm_state_e        st
);
    a_r2_sync_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYNC) |-> !line_oe);

    a_r4_null_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NULL) |-> !line_oe);

    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !line_oe);

    a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !restart_req) |=> $stable(rd_addr));

    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != $past(rd_addr)) |->
            (rd_addr == ADDR_W'($past(rd_addr) + 1'b1) || rd_addr == '0));

    a_r6_restart_prime: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (st == ST_PRIME && rd_addr == '0 && !line_oe));
endmodule

bind stm_streamer stm_streamer_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .restart_req(restart_req),
    .line_oe(line_oe), .rd_addr(rd_addr), .st(st_q)
);

// File: tb/stm_streamer_tb_top.sv
`timescale 1ns/1ps
module stm_streamer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strm_clk = 1'b0;
    logic       run_en = 1'b1;
    logic       restart_req = 1'b0;
    logic [6:0] rd_addr;
    logic [7:0] rd_data = 8'h00;
    logic       line_oe, line_dat;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    stm_streamer dut_i (
        .clk(clk), .rst_n(rst_n), .strm_clk(strm_clk), .run_en(run_en),
        .restart_req(restart_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .line_oe(line_oe), .line_dat(line_dat)
    );

    function automatic logic [7:0] memf(input logic [6:0] a);
        return 8'({1'b0, a} * 8'd37 + 8'd11);
    endfunction

    // array model: one clock read latency (R8)
    always @(posedge clk) rd_data <= memf(rd_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic rise();
        strm_clk = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic fall();
        strm_clk = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_bits(input logic [6:0] a, input int hi, input int lo);
        for (int b = hi; b >= lo; b--) begin
            logic [7:0] v;
            v = memf(a);
            rise();
            chk(line_oe && line_dat == v[b], "R3 bit", {line_oe, line_dat}, {1'b1, v[b]});
            fall();
            chk(line_oe && line_dat == v[b], "R3 falling edge", {line_oe, line_dat}, {1'b1, v[b]});
        end
    endtask

    task automatic check_null(input logic [6:0] a);
        logic [6:0] nx;
        nx = a + 7'd1;
        rise();
        chk(!line_oe, "R4 null slot", line_oe, 0);
        chk(rd_addr == nx, "R8 fetch addr", rd_addr, nx);
        fall();
    endtask

    task automatic check_byte(input logic [6:0] a);
        check_bits(a, 7, 0);
        check_null(a);
    endtask

    task automatic t_reset();
        chk(!line_oe, "R1 line released", line_oe, 0);
        chk(rd_addr == 7'd0, "R1 addr", rd_addr, 0);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        v = memf(7'd0);
        for (int i = 1; i <= 9; i++) begin
            rise();
            chk(!line_oe, "R2 window", line_oe, 0);
            fall();
        end
        rise();
        chk(line_oe && line_dat == v[7], "R2 tenth edge", {line_oe, line_dat}, {1'b1, v[7]});
        fall();
        check_bits(7'd0, 6, 0);
        check_null(7'd0);
    endtask

    task automatic t_wrap();
        for (int a = 1; a < 128; a++) check_byte(7'(a));
        chk(rd_addr == 7'd0, "R5 wrap", rd_addr, 0);
        check_byte(7'd0);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        v = memf(7'd1);
        check_bits(7'd1, 7, 4);
        run_en = 1'b0;
        @(negedge clk);
        chk(!line_oe, "R7 released", line_oe, 0);
        for (int i = 0; i < 5; i++) begin
            rise();
            fall();
        end
        chk(!line_oe, "R7 still released", line_oe, 0);
        chk(rd_addr == 7'd1, "R7 addr frozen", rd_addr, 1);
        run_en = 1'b1;
        @(negedge clk);
        chk(line_oe && line_dat == v[4], "R7 resume bit", {line_oe, line_dat}, {1'b1, v[4]});
        check_bits(7'd1, 3, 0);
        check_null(7'd1);
    endtask

    task automatic t_restart();
        check_bits(7'd2, 7, 5);
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
        @(negedge clk);
        chk(!line_oe, "R6 released", line_oe, 0);
        chk(rd_addr == 7'd0, "R6 addr", rd_addr, 0);
        check_byte(7'd0);
        check_byte(7'd1);
    endtask

    task automatic t_restart_in_sync();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            rise();
            chk(!line_oe, "R2 window again", line_oe, 0);
            fall();
        end
        restart_req = 1'b1;
        @(negedge clk);
        restart_req = 1'b0;
        @(negedge clk);
        chk(rd_addr == 7'd0, "R6 restart in window", rd_addr, 0);
        check_byte(7'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync();
        t_wrap();
        t_disable();
        t_restart();
        t_restart_in_sync();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule